// File: doc/BRIEF.md
# Program Counter and Subroutine Link Sequencer

This block works out the next 16-bit program counter for each instruction the core has decoded. It also keeps subroutine return addresses on a byte-wide stack held in an internal RAM with 8-bit addresses. The decoder hands over one request at a time. Each request carries a jump kind together with the current PC and the operands the chosen kind needs: instruction length, an 11-bit in-page address, a 16-bit absolute address, a signed 8-bit displacement, the accumulator, the data pointer and the carry flag.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a call or a return is moving bytes to or from the stack. A request that is presented while `req_ready` is low is neither taken nor remembered, and the source must hold it until it is accepted. The resulting PC is delivered on `npc` with a one-cycle `npc_valid` pulse. That output has no back-pressure, so the consumer must take it in that cycle. The stack RAM is outside the block and must return read data in the same cycle as the address (asynchronous read). Writes take effect on the clock edge.

Top module: `pc_link_seq`

## Requirements
- R1: After reset, `stack_ptr` is 07h, `req_ready` is 1, and `npc_valid`, `ram_we` and `ram_re` are 0.
- R2: Kind code 0 (sequential), and any code from 11 to 15, produce `npc = cur_pc + instr_len` modulo 65536.
- R3: Kind code 1 (in-page jump) produces a PC whose bits 15..11 come from `cur_pc + 2` and whose bits 10..0 are `page_addr`.
- R4: Kind code 3 (long jump) produces `npc = abs_addr`.
- R5: Kind code 4 (relative jump) produces `cur_pc + instr_len + sext(rel_off)`, where `rel_off` is two's complement in the range -128..+127 and the sum wraps modulo 65536.
- R6: Conditional kinds add the displacement to `cur_pc + instr_len` only when their condition holds, and otherwise give `cur_pc + instr_len`. The kinds are: code 5, taken when carry is 1; code 6, taken when carry is 0; code 7, taken when acc is zero; code 8, taken when acc is non-zero.
- R7: Kind code 9 (indirect jump) produces `dptr + acc` (acc zero-extended), modulo 65536.
- R8: Kind code 2 (in-page call) saves the return address `cur_pc + 2` in the two cycles after acceptance. It first writes the low byte to address `stack_ptr + 1`, then writes the high byte to `stack_ptr + 2`. `stack_ptr` ends 2 higher, and the next PC is formed as in R3.
- R9: Kind code 10 (return) reads the high byte at `stack_ptr` in the first cycle after acceptance and the low byte at `stack_ptr - 1` in the second. `stack_ptr` ends 2 lower, and `npc` is {high, low}.
- R10: `req_ready` is low exactly during the two stack cycles, and a request offered in those cycles has no effect. Every accepted request yields exactly one `npc_valid` pulse. For non-stack kinds the pulse comes one cycle after acceptance, and for calls and returns it comes three cycles after. `stack_ptr` changes only during stack cycles.
- R11: `stack_ptr` is 8 bits wide and wraps modulo 256 in both directions. A push from FFh writes address 00h, and a pop that runs from 01h to 00h leaves FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 4 | Jump kind code (see R2 to R9) |
| cur_pc | input | 16 | PC of the current instruction |
| instr_len | input | 2 | Byte length of the current instruction |
| page_addr | input | 11 | In-page target for jump/call |
| abs_addr | input | 16 | Absolute target for long jump |
| rel_off | input | 8 | Signed displacement |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| carry | input | 1 | Carry flag |
| npc_valid | output | 1 | One-cycle pulse marking a new PC |
| npc | output | 16 | Next program counter |
| stack_ptr | output | 8 | Current stack pointer |
| ram_we | output | 1 | Stack RAM write enable |
| ram_re | output | 1 | Stack RAM read strobe |
| ram_addr | output | 8 | Stack RAM address |
| ram_wdata | output | 8 | Stack RAM write data |
| ram_rdata | input | 8 | Stack RAM read data (same cycle) |

## Verification
The hardest behaviour to reach from the ports is the stack pointer crossing FFh/00h, because it moves only two steps per call. The bench therefore chains 124 calls after the first call/return pair to walk the pointer from 07h up to FFh. One more call then wraps the writes to 00h and 01h, and two returns read back across the boundary. The other hard case is a request offered during the busy cycles of a call. A long-jump request is held valid through both push cycles, and the bench checks that the only PC delivered is the call target and that no second pulse follows.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

  typedef enum logic [3:0] {
    K_SEQ    = 4'd0,
    K_PGJMP  = 4'd1,
    K_PGCALL = 4'd2,
    K_LJMP   = 4'd3,
    K_RJMP   = 4'd4,
    K_BC     = 4'd5,
    K_BNC    = 4'd6,
    K_BZ     = 4'd7,
    K_BNZ    = 4'd8,
    K_IJMP   = 4'd9,
    K_RET    = 4'd10
  } jkind_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH_LO = 3'd1,
    ST_PUSH_HI = 3'd2,
    ST_POP_HI  = 3'd3,
    ST_POP_LO  = 3'd4
  } stk_state_e;

endpackage

// File: rtl/pc_target_calc.sv
module pc_target_calc
  import pc_seq_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int PAGE_W = 11,
  parameter int OFF_W  = 8,
  parameter int LEN_W  = 2
) (
  input  logic [3:0]        kind,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [LEN_W-1:0]  instr_len,
  input  logic [PAGE_W-1:0] page_addr,
  input  logic [PC_W-1:0]   abs_addr,
  input  logic [OFF_W-1:0]  rel_off,
  input  logic [OFF_W-1:0]  acc,
  input  logic [PC_W-1:0]   dptr,
  input  logic              carry,
  output logic [PC_W-1:0]   target,
  output logic [PC_W-1:0]   ret_addr
);

  localparam int EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] fall_pc;
  logic [PC_W-1:0] adv2_pc;
  logic [PC_W-1:0] rel_pc;
  logic [PC_W-1:0] page_pc;
  logic [PC_W-1:0] ind_pc;
  logic            acc_zero;

  always_comb begin
    fall_pc  = cur_pc + PC_W'(instr_len);
    adv2_pc  = cur_pc + PC_W'(2);
    rel_pc   = fall_pc + {{EXT_W{rel_off[OFF_W-1]}}, rel_off};
    page_pc  = {adv2_pc[PC_W-1:PAGE_W], page_addr};
    ind_pc   = dptr + PC_W'(acc);
    acc_zero = (acc == '0);
    ret_addr = adv2_pc;

    case (kind)
      K_PGJMP, K_PGCALL: target = page_pc;
      K_LJMP:            target = abs_addr;
      K_RJMP:            target = rel_pc;
      K_BC:              target = carry     ? rel_pc : fall_pc;
      K_BNC:             target = !carry    ? rel_pc : fall_pc;
      K_BZ:              target = acc_zero  ? rel_pc : fall_pc;
      K_BNZ:             target = !acc_zero ? rel_pc : fall_pc;
      K_IJMP:            target = ind_pc;
      default:           target = fall_pc;
    endcase
  end

endmodule

// File: rtl/link_stack_ctrl.sv
module link_stack_ctrl
  import pc_seq_pkg::*;
#(
  parameter int              SP_W     = 8,
  parameter int              DATA_W   = 8,
  parameter logic [SP_W-1:0] SP_RESET = 8'h07
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_call,
  input  logic                start_ret,
  input  logic [2*DATA_W-1:0] ret_addr,
  input  logic [DATA_W-1:0]   ram_rdata,
  output logic                busy,
  output logic                ram_we,
  output logic                ram_re,
  output logic [SP_W-1:0]     ram_addr,
  output logic [DATA_W-1:0]   ram_wdata,
  output logic [SP_W-1:0]     sp,
  output logic                push_done,
  output logic                pop_done,
  output logic [2*DATA_W-1:0] popped
);

  stk_state_e          state_q;
  logic [SP_W-1:0]     sp_q;
  logic [2*DATA_W-1:0] ret_q;
  logic [DATA_W-1:0]   hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sp_q    <= SP_RESET;
      ret_q   <= '0;
      hi_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_call) begin
            ret_q   <= ret_addr;
            state_q <= ST_PUSH_LO;
          end else if (start_ret) begin
            state_q <= ST_POP_HI;
          end
        end
        ST_PUSH_LO: begin
          sp_q    <= sp_q + 1'b1;
          state_q <= ST_PUSH_HI;
        end
        ST_PUSH_HI: begin
          sp_q    <= sp_q + 1'b1;
          state_q <= ST_IDLE;
        end
        ST_POP_HI: begin
          hi_q    <= ram_rdata;
          sp_q    <= sp_q - 1'b1;
          state_q <= ST_POP_LO;
        end
        ST_POP_LO: begin
          sp_q    <= sp_q - 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (state_q != ST_IDLE);
    ram_we    = (state_q == ST_PUSH_LO) || (state_q == ST_PUSH_HI);
    ram_re    = (state_q == ST_POP_HI)  || (state_q == ST_POP_LO);
    ram_addr  = ram_we ? sp_q + 1'b1 : sp_q;
    ram_wdata = (state_q == ST_PUSH_LO) ? ret_q[DATA_W-1:0]
                                        : ret_q[2*DATA_W-1:DATA_W];
    push_done = (state_q == ST_PUSH_HI);
    pop_done  = (state_q == ST_POP_LO);
    popped    = {hi_q, ram_rdata};
    sp        = sp_q;
  end

endmodule

// File: rtl/pc_link_seq.sv
module pc_link_seq
  import pc_seq_pkg::*;
#(
  parameter int              DATA_W   = 8,
  parameter int              PAGE_W   = 11,
  parameter int              SP_W     = 8,
  parameter int              LEN_W    = 2,
  parameter logic [SP_W-1:0] SP_RESET = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_kind,
  input  logic [15:0]       cur_pc,
  input  logic [LEN_W-1:0]  instr_len,
  input  logic [PAGE_W-1:0] page_addr,
  input  logic [15:0]       abs_addr,
  input  logic [DATA_W-1:0] rel_off,
  input  logic [DATA_W-1:0] acc,
  input  logic [15:0]       dptr,
  input  logic              carry,
  output logic              npc_valid,
  output logic [15:0]       npc,
  output logic [SP_W-1:0]   stack_ptr,
  output logic              ram_we,
  output logic              ram_re,
  output logic [SP_W-1:0]   ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);

  localparam int PC_W = 2 * DATA_W;

  logic            busy;
  logic            accept;
  logic            is_call;
  logic            is_ret;
  logic [PC_W-1:0] target;
  logic [PC_W-1:0] ret_addr;
  logic [PC_W-1:0] popped;
  logic            push_done;
  logic            pop_done;
  logic [PC_W-1:0] pend_q;
  logic [PC_W-1:0] npc_q;
  logic            npc_vld_q;

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign is_call   = (req_kind == K_PGCALL);
  assign is_ret    = (req_kind == K_RET);

  pc_target_calc #(
    .PC_W(PC_W), .PAGE_W(PAGE_W), .OFF_W(DATA_W), .LEN_W(LEN_W)
  ) u_calc (
    .kind(req_kind), .cur_pc(cur_pc), .instr_len(instr_len),
    .page_addr(page_addr), .abs_addr(abs_addr), .rel_off(rel_off),
    .acc(acc), .dptr(dptr), .carry(carry),
    .target(target), .ret_addr(ret_addr)
  );

  link_stack_ctrl #(
    .SP_W(SP_W), .DATA_W(DATA_W), .SP_RESET(SP_RESET)
  ) u_stack (
    .clk(clk), .rst_n(rst_n),
    .start_call(accept && is_call), .start_ret(accept && is_ret),
    .ret_addr(ret_addr), .ram_rdata(ram_rdata),
    .busy(busy), .ram_we(ram_we), .ram_re(ram_re),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .sp(stack_ptr),
    .push_done(push_done), .pop_done(pop_done), .popped(popped)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      npc_q     <= '0;
      npc_vld_q <= 1'b0;
    end else begin
      npc_vld_q <= 1'b0;
      if (accept && is_call) begin
        pend_q <= target;
      end
      if (accept && !is_call && !is_ret) begin
        npc_q     <= target;
        npc_vld_q <= 1'b1;
      end else if (push_done) begin
        npc_q     <= pend_q;
        npc_vld_q <= 1'b1;
      end else if (pop_done) begin
        npc_q     <= popped;
        npc_vld_q <= 1'b1;
      end
    end
  end

  assign npc_valid = npc_vld_q;
  assign npc       = npc_q;

endmodule

// File: rtl/pc_link_seq_chk.sv
module pc_link_seq_chk
  import pc_seq_pkg::*;
#(
  parameter int SP_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [3:0]      req_kind,
  input logic            npc_valid,
  input logic [SP_W-1:0] stack_ptr,
  input logic            ram_we,
  input logic            ram_re,
  input logic [SP_W-1:0] ram_addr
);

  // R10
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || ram_re) |-> !req_ready);

  // R10
  simple_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind != K_PGCALL && req_kind != K_RET)
      |=> npc_valid);

  // R8
  push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> (stack_ptr == $past(ram_addr)));

  // R9
  pop_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_re |=> (stack_ptr == SP_W'($past(ram_addr) - 1'b1)));

  // R10
  sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_we && !ram_re) |=> (stack_ptr == $past(stack_ptr)));

endmodule

bind pc_link_seq pc_link_seq_chk #(.SP_W(SP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_kind(req_kind), .npc_valid(npc_valid), .stack_ptr(stack_ptr),
  .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr)
);

// File: tb/test_pc_link_seq.sv
`timescale 1ns/1ps
module test_pc_link_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [3:0]  req_kind;
  logic [15:0] cur_pc;
  logic [1:0]  instr_len;
  logic [10:0] page_addr;
  logic [15:0] abs_addr;
  logic [7:0]  rel_off;
  logic [7:0]  acc;
  logic [15:0] dptr;
  logic        carry;
  logic        npc_valid;
  logic [15:0] npc;
  logic [7:0]  stack_ptr;
  logic        ram_we;
  logic        ram_re;
  logic [7:0]  ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata;

  int tests = 0;
  int fails = 0;
  logic [7:0] exp_sp;
  logic [7:0] mem [256];

  always #4 clk = ~clk;

  pc_link_seq i_pc_link_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .cur_pc(cur_pc), .instr_len(instr_len),
    .page_addr(page_addr), .abs_addr(abs_addr), .rel_off(rel_off),
    .acc(acc), .dptr(dptr), .carry(carry), .npc_valid(npc_valid),
    .npc(npc), .stack_ptr(stack_ptr), .ram_we(ram_we), .ram_re(ram_re),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;
  assign ram_rdata = mem[ram_addr];

  typedef struct packed {
    logic [3:0]  kind;
    logic [15:0] cur;
    logic [1:0]  len;
    logic [10:0] page;
    logic [15:0] absa;
    logic [7:0]  off;
    logic [7:0]  acc;
    logic [15:0] dptr;
    logic        cy;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    // R2 sequential, plain and wrapping
    '{4'd0,  16'h0100, 2'd1, 11'h3FF, 16'hAAAA, 8'h80, 8'h00, 16'h5555, 1'b1, 16'h0101, 4'd2},
    '{4'd0,  16'hFFFF, 2'd3, 11'h000, 16'h0000, 8'h7F, 8'h00, 16'h0000, 1'b0, 16'h0002, 4'd2},
    // R3 in-page jump, incl. the +2 carrying into bit 11
    '{4'd1,  16'h27FE, 2'd2, 11'h123, 16'hFFFF, 8'h00, 8'h00, 16'h0000, 1'b0, 16'h2923, 4'd3},
    '{4'd1,  16'h4000, 2'd2, 11'h7FF, 16'h0000, 8'h00, 8'h00, 16'h0000, 1'b0, 16'h47FF, 4'd3},
    // R4 long jump
    '{4'd3,  16'h1111, 2'd3, 11'h555, 16'hBEEF, 8'h12, 8'h00, 16'h0000, 1'b0, 16'hBEEF, 4'd4},
    // R5 relative jump, both extremes and wrap
    '{4'd4,  16'h1000, 2'd2, 11'h000, 16'h0000, 8'h80, 8'h00, 16'h0000, 1'b0, 16'h0F82, 4'd5},
    '{4'd4,  16'h1000, 2'd2, 11'h000, 16'h0000, 8'h7F, 8'h00, 16'h0000, 1'b0, 16'h1081, 4'd5},
    '{4'd4,  16'hFFF0, 2'd2, 11'h000, 16'h0000, 8'h20, 8'h00, 16'h0000, 1'b0, 16'h0012, 4'd5},
    // R6 conditional branches, taken and not taken
    '{4'd5,  16'h2000, 2'd2, 11'h000, 16'h0000, 8'h10, 8'h00, 16'h0000, 1'b1, 16'h2012, 4'd6},
    '{4'd5,  16'h2000, 2'd2, 11'h000, 16'h0000, 8'h10, 8'h00, 16'h0000, 1'b0, 16'h2002, 4'd6},
    '{4'd6,  16'h2000, 2'd2, 11'h000, 16'h0000, 8'hF0, 8'h00, 16'h0000, 1'b0, 16'h1FF2, 4'd6},
    '{4'd6,  16'h2000, 2'd2, 11'h000, 16'h0000, 8'hF0, 8'h00, 16'h0000, 1'b1, 16'h2002, 4'd6},
    '{4'd7,  16'h3000, 2'd2, 11'h000, 16'h0000, 8'h05, 8'h00, 16'h0000, 1'b1, 16'h3007, 4'd6},
    '{4'd7,  16'h3000, 2'd2, 11'h000, 16'h0000, 8'h05, 8'h01, 16'h0000, 1'b0, 16'h3002, 4'd6},
    '{4'd8,  16'h3000, 2'd2, 11'h000, 16'h0000, 8'h05, 8'h80, 16'h0000, 1'b0, 16'h3007, 4'd6},
    '{4'd8,  16'h3000, 2'd2, 11'h000, 16'h0000, 8'h05, 8'h00, 16'h0000, 1'b1, 16'h3002, 4'd6},
    // R7 indirect jump, plain and wrapping
    '{4'd9,  16'h0000, 2'd1, 11'h000, 16'h0000, 8'h00, 8'h34, 16'h1200, 1'b0, 16'h1234, 4'd7},
    '{4'd9,  16'h0000, 2'd1, 11'h000, 16'h0000, 8'h00, 8'hFF, 16'hFFF0, 1'b0, 16'h00EF, 4'd7},
    // R2 unused kind code acts as sequential
    '{4'd15, 16'h0500, 2'd2, 11'h7FF, 16'h9999, 8'h44, 8'h00, 16'h0000, 1'b1, 16'h0502, 4'd2}
  };

  task automatic chk(input logic ok, input string tag,
                     input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic clear_inputs();
    req_valid = 1'b0; req_kind = '0; cur_pc = '0; instr_len = '0;
    page_addr = '0; abs_addr = '0; rel_off = '0; acc = '0; dptr = '0;
    carry = 1'b0;
  endtask

  // R8 call: two pushes then the page target
  task automatic do_call(input logic [15:0] pc, input logic [10:0] pg,
                         input bit offer_during_busy);
    logic [15:0] ret;
    logic [15:0] tgt;
    ret = pc + 16'd2;
    tgt = {ret[15:11], pg};
    @(negedge clk);
    req_valid = 1'b1; req_kind = 4'd2; cur_pc = pc; page_addr = pg;
    instr_len = 2'd2;
    @(negedge clk);
    req_valid = 1'b0;
    chk(ram_we && !req_ready, "R8 push lo strobe", {30'd0, ram_we, req_ready}, 32'h2);
    chk(ram_addr == 8'(exp_sp + 8'd1), "R8 push lo addr", ram_addr, 8'(exp_sp + 8'd1));
    chk(ram_wdata == ret[7:0], "R8 push lo data", ram_wdata, ret[7:0]);
    if (offer_during_busy) begin
      req_valid = 1'b1; req_kind = 4'd3; abs_addr = 16'hDEAD;
    end
    @(negedge clk);
    chk(ram_we && !req_ready, "R10 push hi stall", {30'd0, ram_we, req_ready}, 32'h2);
    chk(ram_addr == 8'(exp_sp + 8'd2), "R11 push hi addr", ram_addr, 8'(exp_sp + 8'd2));
    chk(ram_wdata == ret[15:8], "R8 push hi data", ram_wdata, ret[15:8]);
    @(negedge clk);
    req_valid = 1'b0;
    exp_sp = 8'(exp_sp + 8'd2);
    chk(npc_valid && npc == tgt, "R8 call target", npc, tgt);
    chk(stack_ptr == exp_sp, "R8 sp after call", stack_ptr, exp_sp);
    if (offer_during_busy) begin
      @(negedge clk);
      chk(!npc_valid, "R10 request during busy ignored", npc_valid, 0);
      chk(stack_ptr == exp_sp, "R10 sp unchanged", stack_ptr, exp_sp);
    end
  endtask

  // R9 return: pop high at sp, low at sp-1
  task automatic do_ret(input logic [15:0] expect_pc);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 4'd10; cur_pc = 16'h7777;
    @(negedge clk);
    req_valid = 1'b0;
    chk(ram_re && !req_ready, "R9 pop hi strobe", {30'd0, ram_re, req_ready}, 32'h2);
    chk(ram_addr == exp_sp, "R9 pop hi addr", ram_addr, exp_sp);
    @(negedge clk);
    chk(ram_re && ram_addr == 8'(exp_sp - 8'd1), "R11 pop lo addr", ram_addr, 8'(exp_sp - 8'd1));
    @(negedge clk);
    exp_sp = 8'(exp_sp - 8'd2);
    chk(npc_valid && npc == expect_pc, "R9 return pc", npc, expect_pc);
    chk(stack_ptr == exp_sp, "R9 sp after return", stack_ptr, exp_sp);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 8'h00;
    clear_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    exp_sp = 8'h07;
    // R1 reset state
    @(negedge clk);
    chk(stack_ptr == 8'h07, "R1 sp reset", stack_ptr, 8'h07);
    chk(req_ready && !npc_valid && !ram_we && !ram_re, "R1 idle outputs",
        {28'd0, req_ready, npc_valid, ram_we, ram_re}, 32'h8);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_valid = 1'b1; req_kind = VECS[i].kind; cur_pc = VECS[i].cur;
      instr_len = VECS[i].len; page_addr = VECS[i].page;
      abs_addr = VECS[i].absa; rel_off = VECS[i].off; acc = VECS[i].acc;
      dptr = VECS[i].dptr; carry = VECS[i].cy;
      @(negedge clk);
      req_valid = 1'b0;
      tests++;
      if (!(npc_valid && npc == VECS[i].exp)) begin
        fails++;
        $display("FAIL R%0d vector %0d: actual %0h expected %0h",
                 VECS[i].req, i, npc, VECS[i].exp);
      end
    end
    // R10 non-stack kinds leave the stack pointer alone
    chk(stack_ptr == 8'h07, "R10 sp after vectors", stack_ptr, 8'h07);

    clear_inputs();
    do_call(16'h1234, 11'h7AB, 1'b1);
    do_ret(16'h1236);

    // R11 walk sp up to FFh, then wrap
    for (int k = 0; k < 124; k++) do_call(16'h8000 + 16'(k), 11'(k), 1'b0);
    chk(stack_ptr == 8'hFF, "R11 sp at top", stack_ptr, 8'hFF);
    do_call(16'hABCD, 11'h001, 1'b0);
    chk(mem[8'h00] == 8'hCF && mem[8'h01] == 8'hAB, "R11 wrapped bytes",
        {mem[8'h01], mem[8'h00]}, 16'hABCF);
    do_ret(16'hABCF);
    do_ret(16'h807D);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL R10 watchdog expired: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule